// File: doc/BRIEF.md
# Single-Cycle Sequential Processor Core

This block is a small 32-bit processor that completes one whole instruction in every clock cycle. The program counter, the three condition flags, the eight general registers and a run/stop status are the only state it holds. Between two clock edges, plain combinational logic does all of the following:

- reads the instruction bytes at the program counter;
- splits the opcode byte and works out the instruction length;
- reads the registers;
- computes in the ALU;
- drives the data-memory port;
- picks the next program counter.

Instruction memory sits outside the core. It is a read-only port that returns six bytes starting at the requested address, with no clock delay. Data memory also sits outside. It returns a word for the address the core drives, with no clock delay, and stores a word on the rising clock edge when the core asks for a write.

The supported instructions are:

- halt and no-operation;
- register-to-register move and constant-to-register move;
- store and load at a base register plus displacement;
- four ALU operations;
- unconditional and conditional jumps;
- call and return through a stack held in register 4.

A halt or an unknown encoding stops the core. The status output then reports which of the two happened.

Top module: `core_seq`

## Requirements
- R1: The first instruction byte gives the operation in its upper nibble and the function in its lower nibble. The operation codes are: 0 halt, 1 no-op, 2 register move, 3 constant move, 4 store, 5 load, 6 ALU, 7 jump, 8 call, 9 return.
- R2: Instruction length is 1, plus 1 when a register byte follows the opcode byte, plus 4 when a constant word follows. Operations 2 and 6 carry a register byte. Operations 7 and 8 carry a constant. Operations 3, 4 and 5 carry both. The register byte holds rA in its upper nibble and rB in its lower nibble. The constant is little-endian.
- R3: Register identifiers 8 and above mean "no register". Reading one gives 0, and writing one changes no register.
- R4: An ALU operation writes rB op rA into rB. Function 0 is add, 1 is subtract (rB minus rA), 2 is and, 3 is xor. Only ALU operations update the zero, sign and overflow flags.
- R5: A jump goes to its constant when its condition holds and to the next sequential instruction otherwise. The function selects the condition: 0 always, 1 less-or-equal, 2 less, 3 equal, 4 not-equal, 5 greater-or-equal, 6 greater. The conditions are signed and use the flags.
- R6: A call stores the address of the following instruction at register 4 minus 4, sets register 4 to that address, and continues at its constant.
- R7: A return continues at the word read from the address in register 4, and adds 4 to register 4.
- R8: A store writes rA to address rB plus constant. A load writes the word at rB plus constant into rA.
- R9: A halt sets status to 1. After that the program counter, the registers and memory no longer change.
- R10: An unknown operation, an ALU function above 3, or a jump function above 6 sets status to 2 and freezes the core the same way.
- R11: Reset sets the program counter to 0, status to 0 (running), and every register and flag to 0.
- R12: A register move copies rA into rB. A constant move writes the constant into rB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 32 | Program counter, used as the instruction fetch address |
| imem_bytes | input | 48 | Six bytes starting at imem_addr; byte 0 in bits 7:0 |
| dmem_addr | output | 32 | Data memory word address |
| dmem_wdata | output | 32 | Word to store |
| dmem_we | output | 1 | Store strobe, taken on the next rising edge |
| dmem_rdata | input | 32 | Word at dmem_addr, combinational |
| core_status | output | 2 | 0 running, 1 halted, 2 bad instruction |

## Verification
The bench runs short programs and then reads results back from data memory and from the fetch address. It targets flag-driven jumps with and without signed overflow. A core that ignores overflow would take a "less" jump after a positive-plus-positive sum wraps negative, and a marker store would then go missing.

Register identifier 8 is used both as a base and as a destination. A design that only decodes the low three bits would read register 0 as the base, or clobber register 0 on the write. Call and return check both the pushed return address and the restored stack register, which catches any off-by-four in the stack arithmetic.

Halt and illegal encodings must freeze the fetch address exactly at the stopping byte. A core that kept counting would show a moving address or would execute the store placed after the bad byte.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int XLEN  = 32;
  localparam int NREG  = 8;
  localparam int RID_W = 4;
  localparam int SP_ID = 4;

  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [3:0] {
    OP_HALT  = 4'h0,
    OP_NOP   = 4'h1,
    OP_MOVRR = 4'h2,
    OP_MOVIR = 4'h3,
    OP_STORE = 4'h4,
    OP_LOAD  = 4'h5,
    OP_ALU   = 4'h6,
    OP_JUMP  = 4'h7,
    OP_CALL  = 4'h8,
    OP_RET   = 4'h9
  } op_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_BAD  = 2'd2
  } status_e;

  // address of the following instruction
  function automatic word_t step_pc(word_t pc, logic regs, logic cw);
    return pc + word_t'(1) + (regs ? word_t'(1) : word_t'(0)) + (cw ? word_t'(4) : word_t'(0));
  endfunction

  function automatic word_t alu_res(logic [1:0] fn, word_t a, word_t b);
    case (fn)
      2'd0:    return b + a;
      2'd1:    return b - a;
      2'd2:    return b & a;
      default: return b ^ a;
    endcase
  endfunction

  function automatic logic alu_ovf(logic [1:0] fn, word_t a, word_t b, word_t r);
    case (fn)
      2'd0:    return (a[XLEN-1] == b[XLEN-1]) && (r[XLEN-1] != a[XLEN-1]);
      2'd1:    return (a[XLEN-1] != b[XLEN-1]) && (r[XLEN-1] != b[XLEN-1]);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic cond_ok(logic [3:0] fn, logic zf, logic sf, logic of);
    case (fn)
      4'd0:    return 1'b1;
      4'd1:    return (sf ^ of) | zf;
      4'd2:    return sf ^ of;
      4'd3:    return zf;
      4'd4:    return !zf;
      4'd5:    return !(sf ^ of);
      4'd6:    return !(sf ^ of) && !zf;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/core_fetch.sv
module core_fetch
  import core_pkg::*;
(
  input  word_t            pc,
  input  logic [47:0]      bytes,
  output logic [3:0]       op,
  output logic [3:0]       fn,
  output logic [RID_W-1:0] ra,
  output logic [RID_W-1:0] rb,
  output word_t            cval,
  output word_t            seq_pc,
  output logic             legal,
  output logic             has_regs,
  output logic             has_const
);
  always_comb begin
    op        = bytes[7:4];
    fn        = bytes[3:0];
    legal     = 1'b1;
    has_regs  = 1'b0;
    has_const = 1'b0;
    case (bytes[7:4])
      OP_HALT, OP_NOP, OP_RET: ;
      OP_MOVRR:                has_regs = 1'b1;
      OP_MOVIR, OP_STORE, OP_LOAD: begin
        has_regs  = 1'b1;
        has_const = 1'b1;
      end
      OP_ALU: begin
        has_regs = 1'b1;
        legal    = (bytes[3:0] < 4'd4);
      end
      OP_JUMP: begin
        has_const = 1'b1;
        legal     = (bytes[3:0] < 4'd7);
      end
      OP_CALL:                 has_const = 1'b1;
      default:                 legal = 1'b0;
    endcase
    ra     = has_regs ? bytes[15:12] : RID_W'(NREG);
    rb     = has_regs ? bytes[11:8]  : RID_W'(NREG);
    cval   = has_regs ? bytes[47:16] : bytes[39:8];
    seq_pc = step_pc(pc, has_regs, has_const);
  end
endmodule

// File: rtl/core_regs.sv
module core_regs
  import core_pkg::*;
#(
  parameter int NUM = NREG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RID_W-1:0] rd_a_id,
  input  logic [RID_W-1:0] rd_b_id,
  output word_t            rd_a,
  output word_t            rd_b,
  input  logic             wr_en,
  input  logic [RID_W-1:0] wr_id,
  input  word_t            wr_data
);
  localparam int IDX_W = $clog2(NUM);
  localparam logic [RID_W-1:0] NONE_MIN = RID_W'(NUM);

  word_t regs [NUM];

  assign rd_a = (rd_a_id < NONE_MIN) ? regs[rd_a_id[IDX_W-1:0]] : '0;
  assign rd_b = (rd_b_id < NONE_MIN) ? regs[rd_b_id[IDX_W-1:0]] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM; i++) regs[i] <= '0;
    end else if (wr_en && (wr_id < NONE_MIN)) begin
      regs[wr_id[IDX_W-1:0]] <= wr_data;
    end
  end

  AST_NONE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_id >= NONE_MIN) |-> (rd_a == '0)); // R3
  AST_NONE_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_id >= NONE_MIN)) |=> $stable(regs[0])); // R3
endmodule

// File: rtl/core_exec.sv
module core_exec
  import core_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] alu_fn,
  input  word_t      a,
  input  word_t      b,
  input  logic       cc_load,
  input  logic [3:0] jfn,
  output word_t      result,
  output logic       cond
);
  logic zf, sf, of;

  assign result = alu_res(alu_fn, a, b);
  assign cond   = cond_ok(jfn, zf, sf, of);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zf <= 1'b0;
      sf <= 1'b0;
      of <= 1'b0;
    end else if (cc_load) begin
      zf <= (result == '0);
      sf <= result[XLEN-1];
      of <= alu_ovf(alu_fn, a, b, result);
    end
  end

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_load |=> $stable({zf, sf, of})); // R4
endmodule

// File: rtl/core_seq.sv
module core_seq
  import core_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [47:0] imem_bytes,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata,
  output logic [1:0]  core_status
);
  word_t            pc_q, next_pc;
  status_e          status_q;
  logic             running, retire;
  logic [3:0]       op, fn;
  logic [RID_W-1:0] ra, rb, rd_b_id, wr_id;
  word_t            cval, seq_pc, val_a, val_b, alu_a, alu_b, result, wr_data;
  logic             legal, has_regs, has_const, cond, wr_en, cc_load;
  logic [1:0]       alu_fn;

  assign running     = (status_q == ST_RUN);
  assign retire      = running && legal && (op != OP_HALT);
  assign imem_addr   = pc_q;
  assign core_status = status_q;

  core_fetch u_fetch (
    .pc(pc_q), .bytes(imem_bytes), .op(op), .fn(fn), .ra(ra), .rb(rb),
    .cval(cval), .seq_pc(seq_pc), .legal(legal),
    .has_regs(has_regs), .has_const(has_const)
  );

  assign rd_b_id = (op == OP_CALL || op == OP_RET) ? RID_W'(SP_ID) : rb;

  core_regs #(.NUM(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .rd_a_id(ra), .rd_b_id(rd_b_id),
    .rd_a(val_a), .rd_b(val_b), .wr_en(wr_en), .wr_id(wr_id), .wr_data(wr_data)
  );

  // operand routing; everything but ALU ops uses add
  always_comb begin
    alu_a  = val_a;
    alu_b  = '0;
    alu_fn = 2'd0;
    case (op)
      OP_MOVIR:          alu_a = cval;
      OP_STORE, OP_LOAD: begin alu_a = cval; alu_b = val_b; end
      OP_ALU:            begin alu_b = val_b; alu_fn = fn[1:0]; end
      OP_CALL:           begin alu_a = -word_t'(4); alu_b = val_b; end
      OP_RET:            begin alu_a = word_t'(4);  alu_b = val_b; end
      default: ;
    endcase
  end

  assign cc_load = retire && (op == OP_ALU);

  core_exec u_exec (
    .clk(clk), .rst_n(rst_n), .alu_fn(alu_fn), .a(alu_a), .b(alu_b),
    .cc_load(cc_load), .jfn(fn), .result(result), .cond(cond)
  );

  assign dmem_addr  = (op == OP_RET) ? val_b : result;
  assign dmem_wdata = (op == OP_CALL) ? seq_pc : val_a;
  assign dmem_we    = retire && (op == OP_STORE || op == OP_CALL);

  always_comb begin
    wr_en   = 1'b0;
    wr_id   = rb;
    wr_data = result;
    case (op)
      OP_MOVRR, OP_MOVIR, OP_ALU: wr_en = retire;
      OP_LOAD: begin wr_en = retire; wr_id = ra; wr_data = dmem_rdata; end
      OP_CALL, OP_RET: begin wr_en = retire; wr_id = RID_W'(SP_ID); end
      default: ;
    endcase
  end

  always_comb begin
    case (op)
      OP_JUMP: next_pc = cond ? cval : seq_pc;
      OP_CALL: next_pc = cval;
      OP_RET:  next_pc = dmem_rdata;
      default: next_pc = seq_pc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      status_q <= ST_RUN;
    end else if (running) begin
      if (!legal)               status_q <= ST_BAD;
      else if (op == OP_HALT)   status_q <= ST_HALT;
      else                      pc_q     <= next_pc;
    end
  end

  AST_STOPPED_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q != ST_RUN) |=> $stable(pc_q)); // R9
  AST_HALT_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    (running && legal && op == OP_HALT) |=> (core_status == ST_HALT)); // R9
  AST_BAD_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !legal) |=> (core_status == ST_BAD)); // R10
  AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (running && op == OP_CALL) |=> (imem_addr == $past(cval))); // R6
  AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (running && op == OP_RET) |=> (imem_addr == $past(dmem_rdata))); // R7
endmodule

// File: tb/core_seq_bench.sv
module core_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, dmem_addr, dmem_wdata, dmem_rdata;
  logic [47:0] imem_bytes;
  logic        dmem_we;
  logic [1:0]  core_status;
  logic [7:0]  im [0:255];
  logic [31:0] dm [0:63];
  int checks = 0;
  int errors = 0;
  int wp = 0;

  always #4 clk = ~clk;

  core_seq u_core_seq (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_bytes(imem_bytes),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .core_status(core_status)
  );

  always_comb
    for (int k = 0; k < 6; k++) imem_bytes[8*k +: 8] = im[imem_addr[7:0] + 8'(k)];
  assign dmem_rdata = dm[dmem_addr[7:2]];
  always @(posedge clk) if (rst_n && dmem_we) dm[dmem_addr[7:2]] <= dmem_wdata;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wipe();
    for (int i = 0; i < 256; i++) im[i] = 8'h00;
    for (int i = 0; i < 64; i++) dm[i] = 32'h0;
    wp = 0;
  endtask

  task automatic emit(input logic [7:0] b);
    im[wp] = b;
    wp++;
  endtask
  task automatic emit32(input logic [31:0] v);
    for (int i = 0; i < 4; i++) emit(v[8*i +: 8]);
  endtask
  task automatic patch32(input int at, input logic [31:0] v);
    for (int i = 0; i < 4; i++) im[at+i] = v[8*i +: 8];
  endtask

  task automatic i_irm(input logic [3:0] rb, input logic [31:0] c);
    emit(8'h30); emit({4'h8, rb}); emit32(c);
  endtask
  task automatic i_rrm(input logic [3:0] ra, input logic [3:0] rb);
    emit(8'h20); emit({ra, rb});
  endtask
  task automatic i_st(input logic [3:0] ra, input logic [3:0] rb, input logic [31:0] c);
    emit(8'h40); emit({ra, rb}); emit32(c);
  endtask
  task automatic i_ld(input logic [3:0] ra, input logic [3:0] rb, input logic [31:0] c);
    emit(8'h50); emit({ra, rb}); emit32(c);
  endtask
  task automatic i_alu(input logic [3:0] f, input logic [3:0] ra, input logic [3:0] rb);
    emit({4'h6, f}); emit({ra, rb});
  endtask
  task automatic i_jmp(input logic [3:0] f, output int at);
    emit({4'h7, f}); at = wp; emit32(32'h0);
  endtask
  task automatic i_call(output int at);
    emit(8'h80); at = wp; emit32(32'h0);
  endtask

  task automatic run(input int limit);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    for (int c = 0; c < limit; c++) begin
      @(negedge clk);
      if (core_status != 2'd0) break;
    end
  endtask

  task automatic t_reset();
    wipe();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R11", "pc in reset", imem_addr, 32'h0);
    check("R11", "status in reset", {30'h0, core_status}, 32'h0);
  endtask

  task automatic t_moves();
    int h;
    wipe();
    i_irm(4'h0, 32'h12345678);
    i_rrm(4'h0, 4'h1);
    i_st(4'h1, 4'h8, 32'h10);
    i_st(4'h2, 4'h8, 32'h08);
    h = wp; emit(8'h00);
    dm[2] = 32'hFFFF_FFFF;
    run(50);
    check("R12", "moved word stored", dm[4], 32'h12345678);
    check("R11", "untouched reg is zero", dm[2], 32'h0);
    check("R9", "halt status", {30'h0, core_status}, 32'h1);
    check("R2", "pc at halt byte", imem_addr, 32'(h));
    repeat (3) @(negedge clk);
    check("R9", "pc frozen after halt", imem_addr, 32'(h));
  endtask

  task automatic t_alu();
    int j1, j2, skip, u;
    wipe();
    i_irm(4'h0, 32'd5);
    i_irm(4'h1, 32'd7);
    i_alu(4'h1, 4'h0, 4'h1);
    i_st(4'h1, 4'h8, 32'h00);
    i_irm(4'h2, 32'hF0F0);
    i_irm(4'h3, 32'h0FF0);
    i_alu(4'h2, 4'h2, 4'h3);
    i_st(4'h3, 4'h8, 32'h04);
    i_alu(4'h3, 4'h0, 4'h0);
    i_jmp(4'h3, j1);
    i_irm(4'h5, 32'hBAD);
    i_st(4'h5, 4'h8, 32'h08);
    skip = wp; patch32(j1, 32'(skip));
    i_irm(4'h4, 32'h7FFF_FFFF);
    i_irm(4'h6, 32'h1);
    i_alu(4'h0, 4'h6, 4'h4);
    i_jmp(4'h2, j2);
    i_irm(4'h7, 32'h600D);
    i_st(4'h7, 4'h8, 32'h0C);
    i_st(4'h4, 4'h8, 32'h10);
    u = wp; patch32(j2, 32'(u));
    emit(8'h00);
    run(80);
    check("R4", "subtract 7-5", dm[0], 32'd2);
    check("R4", "and result", dm[1], 32'h00F0);
    check("R5", "equal jump taken skips store", dm[2], 32'h0);
    check("R5", "less jump not taken on overflow", dm[3], 32'h600D);
    check("R4", "add wraps", dm[4], 32'h8000_0000);
    check("R1", "pc at halt", imem_addr, 32'(u));
  endtask

  task automatic t_call();
    int jc, f, h;
    wipe();
    i_irm(4'h4, 32'h80);
    i_call(jc);
    i_st(4'h4, 4'h8, 32'h40);
    h = wp; emit(8'h00);
    f = wp; patch32(jc, 32'(f));
    i_irm(4'h6, 32'h55);
    i_st(4'h6, 4'h8, 32'h20);
    emit(8'h90);
    run(50);
    check("R6", "callee ran", dm[8], 32'h55);
    check("R6", "return address pushed", dm[31], 32'd11);
    check("R7", "stack reg restored", dm[16], 32'h80);
    check("R7", "pc after return path", imem_addr, 32'(h));
  endtask

  task automatic t_load();
    wipe();
    dm[12] = 32'hCAFE_F00D;
    i_irm(4'h0, 32'h11);
    i_irm(4'h8, 32'h99);
    i_ld(4'h1, 4'h8, 32'h30);
    i_st(4'h1, 4'h8, 32'h34);
    i_st(4'h0, 4'h8, 32'h38);
    emit(8'h00);
    run(50);
    check("R8", "loaded word", dm[13], 32'hCAFE_F00D);
    check("R3", "write to none keeps r0", dm[14], 32'h11);
  endtask

  task automatic t_bad();
    wipe();
    emit(8'h10);
    emit(8'hC0);
    i_irm(4'h0, 32'h7);
    i_st(4'h0, 4'h8, 32'h0);
    emit(8'h00);
    run(50);
    check("R10", "bad status", {30'h0, core_status}, 32'h2);
    check("R10", "pc stuck at bad byte", imem_addr, 32'h1);
    repeat (3) @(negedge clk);
    check("R10", "no store after bad", dm[0], 32'h0);
    wipe();
    emit(8'h67);
    emit(8'h01);
    run(20);
    check("R10", "alu function 7 rejected", {30'h0, core_status}, 32'h2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_moves();
    t_alu();
    t_call();
    t_load();
    t_bad();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule